// File: doc/BRIEF.md
# Wrapping Burst Read Address Sequencer

This block drives the address side of a clocked burst read from a memory array. A one-cycle start strobe captures an initial address and the address space it targets. The block then counts a programmable first-access delay and, from the first valid beat on, issues one array address per clock. Addresses stay inside an aligned group whose size follows from the configured burst length and bus width. In wrapping mode the walk begins at the initial offset. In linear mode it begins at the group base. At the end of each pass it returns to the first beat of the burst and repeats until a new strobe arrives.

A small configuration register, loaded through a write strobe, selects burst enable, bus width, wrapping or linear order, length and delay. The block captures the configuration at each start strobe, so a write during a burst leaves the running burst unchanged. Reads of the configuration and protection spaces, and every read while bursting is disabled, are handled as single reads. These present the start address and hold it while output enable stays active. An active-low group-end flag marks the final beat of each pass. A separate flag marks beats that fall beyond the end of the 256-byte security space.

Top module: `burst_addr_seq`

## Requirements
- R1: A synchronous active-high reset disables bursting, sets the delay to 2, returns to idle with `beat_valid` low and `grp_end_n` high.
- R2: A strobe sampled at clock edge E0 makes the first beat valid after edge E0+L, where L is the stored delay (2 to 16); a written value below 2 is stored as 2 and a value above 16 as 16.
- R3: `cfg_len` selects 4, 8, 16 or 32 sixteen-bit words for codes 0, 1, 2, 3; a pass has that many beats when `cfg_wide`=0 (16-bit bus) and half as many when `cfg_wide`=1 (32-bit bus, addresses count double words).
- R4: In wrapping order (`cfg_linear`=0) a pass of N beats starts at offset `start_addr` mod N and steps by one modulo N, with address bits above the group left unchanged.
- R5: In linear order (`cfg_linear`=1) every pass starts at the group base (offset 0) whatever the initial offset.
- R6: A wrapping request at 32 words, or at 16 words on the 16-bit bus, is run in linear order.
- R7: `grp_end_n` is low exactly on the last beat of each pass; the next beat repeats the first beat of the burst, and beats continue every clock until a new strobe.
- R8: A strobe during a burst aborts it: `beat_valid` is low after the strobe edge and the delay count restarts for the new address.
- R9: With bursting disabled, or with `start_space` 2 (configuration) or 3 (protection), the read is single: `beat_single` high, `beat_addr` equal to the start address, `grp_end_n` high, held while `oe_n` is low; `beat_valid` drops after the first edge that samples `oe_n` high.
- R10: For `start_space` 1 (security space) a burst beat whose address is at or beyond the 256-byte limit (128 on the 16-bit bus, 64 on the 32-bit bus) raises `beat_invalid`; for other beats it is low.
- R11: A configuration write after the strobe does not alter the running burst's length, order or delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_burst_en | input | 1 | Burst enable field |
| cfg_wide | input | 1 | 1 selects 32-bit bus, 0 selects 16-bit bus |
| cfg_linear | input | 1 | 1 selects linear order, 0 wrapping order |
| cfg_len | input | 2 | Burst length code (4/8/16/32 words) |
| cfg_lat | input | LATW | Requested first-access delay in clocks |
| strobe | input | 1 | Start strobe, captures address and space |
| start_addr | input | AW | Initial address in bus units |
| start_space | input | 2 | 0 array, 1 security, 2 configuration, 3 protection |
| oe_n | input | 1 | Active-low output enable for single reads |
| beat_valid | output | 1 | A beat address is being presented |
| beat_addr | output | AW | Address of the current beat |
| beat_single | output | 1 | Current read is a single read |
| beat_invalid | output | 1 | Beat lies past the security space limit |
| grp_end_n | output | 1 | Active-low last-beat-of-pass flag |

## Verification
A wrong beat index or offset shows on `beat_addr` in the very cycle it goes wrong, so every beat of two full passes is compared with an address computed from the requirements. A wrong pass length shows as `grp_end_n` falling one or more beats early or late and as a repeated or skipped address at the wrap, visible within one pass. A wrong delay count shows as `beat_valid` rising on the wrong edge after the strobe, checked at both ends of the delay range and at the clamped values. A stuck or mis-selected single-read state shows as an address that does not hold while `oe_n` is low or that lingers one cycle after release.

// File: rtl/burst_addr_seq.sv
module burst_addr_seq #(
  parameter int AW        = 20,
  parameter int LATW      = 5,
  parameter int LAT_MIN   = 2,
  parameter int LAT_MAX   = 16,
  parameter int SEC_BYTES = 256
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_wr,
  input  logic            cfg_burst_en,
  input  logic            cfg_wide,
  input  logic            cfg_linear,
  input  logic [1:0]      cfg_len,
  input  logic [LATW-1:0] cfg_lat,
  input  logic            strobe,
  input  logic [AW-1:0]   start_addr,
  input  logic [1:0]      start_space,
  input  logic            oe_n,
  output logic            beat_valid,
  output logic [AW-1:0]   beat_addr,
  output logic            beat_single,
  output logic            beat_invalid,
  output logic            grp_end_n
);

  localparam int OFFW = 5;
  localparam logic [AW-1:0] SEC_LIM16 = AW'(SEC_BYTES / 2);
  localparam logic [AW-1:0] SEC_LIM32 = AW'(SEC_BYTES / 4);
  localparam logic [LATW-1:0] LMIN = LATW'(LAT_MIN);
  localparam logic [LATW-1:0] LMAX = LATW'(LAT_MAX);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_BURST, S_SINGLE} st_t;

  logic            en_q, wide_q, lin_q;
  logic [1:0]      len_q;
  logic [LATW-1:0] lat_q;

  st_t             st_q;
  logic [LATW-1:0] cnt_q;
  logic [AW-1:0]   base_q;
  logic [OFFW-1:0] first_q, mask_q, idx_q;
  logic            wide_s, sec_s, single_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      wide_q <= 1'b0;
      lin_q  <= 1'b0;
      len_q  <= 2'd0;
      lat_q  <= LMIN;
    end else if (cfg_wr) begin
      en_q   <= cfg_burst_en;
      wide_q <= cfg_wide;
      lin_q  <= cfg_linear;
      len_q  <= cfg_len;
      lat_q  <= (cfg_lat < LMIN) ? LMIN : (cfg_lat > LMAX) ? LMAX : cfg_lat;
    end
  end

  logic [2:0]      blog;
  logic [OFFW-1:0] mask_n, first_n;
  logic            seq_bad, lin_n, single_n;

  assign blog     = 3'({1'b0, len_q}) + 3'd2 - 3'({2'b0, wide_q});
  assign mask_n   = (OFFW'(1) << blog) - OFFW'(1);
  assign seq_bad  = wide_q ? (len_q == 2'd3) : len_q[1];
  assign lin_n    = lin_q | seq_bad;
  assign first_n  = lin_n ? '0 : (start_addr[OFFW-1:0] & mask_n);
  assign single_n = !en_q || start_space[1];

  logic last;
  assign last = (idx_q == mask_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= S_IDLE;
      cnt_q    <= '0;
      base_q   <= '0;
      first_q  <= '0;
      mask_q   <= '0;
      idx_q    <= '0;
      wide_s   <= 1'b0;
      sec_s    <= 1'b0;
      single_s <= 1'b0;
    end else if (strobe) begin
      st_q     <= S_WAIT;
      cnt_q    <= lat_q;
      idx_q    <= '0;
      wide_s   <= wide_q;
      sec_s    <= (start_space == 2'd1);
      single_s <= single_n;
      if (single_n) begin
        base_q  <= start_addr;
        first_q <= '0;
        mask_q  <= '0;
      end else begin
        base_q  <= start_addr & ~{{(AW-OFFW){1'b0}}, mask_n};
        first_q <= first_n;
        mask_q  <= mask_n;
      end
    end else begin
      case (st_q)
        S_WAIT: begin
          if (cnt_q == LATW'(1)) st_q <= single_s ? S_SINGLE : S_BURST;
          else cnt_q <= cnt_q - LATW'(1);
        end
        S_BURST:  idx_q <= last ? '0 : idx_q + OFFW'(1);
        S_SINGLE: if (oe_n) st_q <= S_IDLE;
        default:  ;
      endcase
    end
  end

  assign beat_addr    = base_q | {{(AW-OFFW){1'b0}}, (first_q + idx_q) & mask_q};
  assign beat_valid   = (st_q == S_BURST) || (st_q == S_SINGLE);
  assign beat_single  = (st_q == S_SINGLE);
  assign grp_end_n    = !((st_q == S_BURST) && last);
  assign beat_invalid = (st_q == S_BURST) && sec_s &&
                        (beat_addr >= (wide_s ? SEC_LIM32 : SEC_LIM16));

endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
  parameter int AW = 20
) (
  input logic          clk,
  input logic          rst,
  input logic          strobe,
  input logic          oe_n,
  input logic          beat_valid,
  input logic [AW-1:0] beat_addr,
  input logic          beat_single,
  input logic          beat_invalid,
  input logic          grp_end_n
);

  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (!beat_valid && grp_end_n));

  a_r2_min_latency: assert property (@(posedge clk) disable iff (rst)
    strobe |=> !beat_valid ##1 !beat_valid);

  a_r8_restart: assert property (@(posedge clk) disable iff (rst)
    strobe |=> !beat_valid);

  a_r7_end_in_burst: assert property (@(posedge clk) disable iff (rst)
    !grp_end_n |-> (beat_valid && !beat_single));

  a_r7_continue: assert property (@(posedge clk) disable iff (rst)
    (beat_valid && !beat_single && !strobe) |=> (beat_valid && !beat_single));

  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    (beat_single && !oe_n && !strobe) |=> (beat_single && $stable(beat_addr)));

  a_r9_release: assert property (@(posedge clk) disable iff (rst)
    (beat_single && oe_n && !strobe) |=> !beat_valid);

  a_r10_invalid_burst_only: assert property (@(posedge clk) disable iff (rst)
    beat_invalid |-> (beat_valid && !beat_single));

endmodule

bind burst_addr_seq burst_addr_seq_chk #(.AW(AW)) u_chk (.*);

// File: tb/sim_burst_addr_seq.sv
module sim_burst_addr_seq;
  localparam int AW = 20;
  localparam int LATW = 5;
  localparam time TCLK = 10ns;

  logic clk = 1'b0;
  logic rst, cfg_wr, cfg_burst_en, cfg_wide, cfg_linear, strobe, oe_n;
  logic [1:0] cfg_len, start_space;
  logic [LATW-1:0] cfg_lat;
  logic [AW-1:0] start_addr;
  logic beat_valid, beat_single, beat_invalid, grp_end_n;
  logic [AW-1:0] beat_addr;

  always #(TCLK/2) clk = ~clk;

  burst_addr_seq #(.AW(AW), .LATW(LATW)) u0 (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_burst_en(cfg_burst_en),
    .cfg_wide(cfg_wide), .cfg_linear(cfg_linear), .cfg_len(cfg_len),
    .cfg_lat(cfg_lat), .strobe(strobe), .start_addr(start_addr),
    .start_space(start_space), .oe_n(oe_n), .beat_valid(beat_valid),
    .beat_addr(beat_addr), .beat_single(beat_single),
    .beat_invalid(beat_invalid), .grp_end_n(grp_end_n));

  typedef struct packed {
    logic        wide;
    logic        lin;
    logic [1:0]  len;
    logic [4:0]  latw;
    logic [4:0]  late;
    logic [1:0]  space;
    logic [19:0] addr;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 1'b0, 2'd0, 5'd2,  5'd2,  2'd0, 20'h00013},  // R4 3-0-1-2
    '{1'b0, 1'b0, 2'd0, 5'd2,  5'd2,  2'd0, 20'h00002},  // R4 2-3-0-1
    '{1'b1, 1'b0, 2'd2, 5'd5,  5'd5,  2'd0, 20'h00105},  // R4 8 beats from 5
    '{1'b1, 1'b0, 2'd0, 5'd16, 5'd16, 2'd0, 20'h00007},  // R4 1-0
    '{1'b1, 1'b1, 2'd1, 5'd3,  5'd3,  2'd0, 20'h00046},  // R5
    '{1'b1, 1'b1, 2'd3, 5'd4,  5'd4,  2'd0, 20'h00123},  // R3 R5 16 beats
    '{1'b0, 1'b1, 2'd3, 5'd2,  5'd2,  2'd0, 20'h0003F},  // R3 R5 32 beats
    '{1'b0, 1'b0, 2'd2, 5'd3,  5'd3,  2'd0, 20'h00015},  // R6 x16 16 words
    '{1'b1, 1'b0, 2'd3, 5'd2,  5'd2,  2'd0, 20'h0001C},  // R6 x32 32 words
    '{1'b0, 1'b0, 2'd1, 5'd0,  5'd2,  2'd0, 20'h00009},  // R2 clamp low
    '{1'b1, 1'b0, 2'd1, 5'd31, 5'd16, 2'd0, 20'h0000B},  // R2 clamp high
    '{1'b0, 1'b0, 2'd1, 5'd2,  5'd2,  2'd1, 20'h00083},  // R10 invalid
    '{1'b1, 1'b0, 2'd1, 5'd2,  5'd2,  2'd1, 20'h00022},  // R10 valid
    '{1'b1, 1'b0, 2'd0, 5'd3,  5'd3,  2'd1, 20'h00041}   // R10 invalid
  };

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic do_cfg(input logic en, input logic wide, input logic lin,
                        input logic [1:0] len, input logic [4:0] lat);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_burst_en = en; cfg_wide = wide; cfg_linear = lin;
    cfg_len = len; cfg_lat = lat;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic do_strobe(input logic [AW-1:0] a, input logic [1:0] sp);
    @(negedge clk);
    strobe = 1'b1; start_addr = a; start_space = sp;
    @(negedge clk);
    strobe = 1'b0;
  endtask

  function automatic logic [AW-1:0] exp_addr(input logic wide, input logic lin,
      input logic [1:0] len, input logic [AW-1:0] a, input int k);
    int n; int first; logic l;
    n = (4 << len) >> wide;
    l = lin || (len == 2'd3) || (!wide && len == 2'd2);
    first = l ? 0 : int'(a) % n;
    return AW'((int'(a) / n) * n + ((first + k) % n));
  endfunction

  // Called right after the strobe edge; checks the delay then two passes.
  task automatic expect_burst(input logic wide, input logic lin, input logic [1:0] len,
      input int late, input logic [AW-1:0] a, input logic [1:0] sp, input string tag);
    int n;
    logic [AW-1:0] ea;
    n = (4 << len) >> wide;
    chk({tag, " delay"}, 32'(beat_valid), 32'd0);
    for (int i = 1; i < late; i++) begin
      @(negedge clk); cfg_wr = 1'b0;
      chk({tag, " delay"}, 32'(beat_valid), 32'd0);
    end
    for (int j = 0; j < 2 * n; j++) begin
      @(negedge clk); cfg_wr = 1'b0;
      ea = exp_addr(wide, lin, len, a, j % n);
      chk({tag, " valid"}, 32'(beat_valid), 32'd1);
      chk({tag, " addr"}, 32'(beat_addr), 32'(ea));
      chk({tag, " R7 grp_end_n"}, 32'(grp_end_n), (j % n == n - 1) ? 32'd0 : 32'd1);
      chk({tag, " R10 invalid"}, 32'(beat_invalid),
          32'((sp == 2'd1) && (ea >= (wide ? 20'd64 : 20'd128))));
    end
  endtask

  task automatic expect_single(input int late, input logic [AW-1:0] a,
      input int hold, input string tag);
    chk({tag, " delay"}, 32'(beat_valid), 32'd0);
    for (int i = 1; i < late; i++) begin
      @(negedge clk);
      chk({tag, " delay"}, 32'(beat_valid), 32'd0);
    end
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk({tag, " single valid"}, 32'(beat_valid), 32'd1);
      chk({tag, " single flag"}, 32'(beat_single), 32'd1);
      chk({tag, " single addr"}, 32'(beat_addr), 32'(a));
      chk({tag, " single grp_end_n"}, 32'(grp_end_n), 32'd1);
    end
    oe_n = 1'b1;
    @(negedge clk);
    chk({tag, " release"}, 32'(beat_valid), 32'd0);
    oe_n = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    rst = 1'b1; cfg_wr = 1'b0; cfg_burst_en = 1'b0; cfg_wide = 1'b0;
    cfg_linear = 1'b0; cfg_len = 2'd0; cfg_lat = '0; strobe = 1'b0;
    start_addr = '0; start_space = 2'd0; oe_n = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 idle outputs, then reset config gives a single read at delay 2
    chk("R1 valid", 32'(beat_valid), 32'd0);
    chk("R1 grp_end_n", 32'(grp_end_n), 32'd1);
    do_strobe(20'h00055, 2'd0);
    expect_single(2, 20'h00055, 3, "R1");

    // R2 R3 R4 R5 R6 R7 R10 table
    for (int v = 0; v < NV; v++) begin
      do_cfg(1'b1, TBL[v].wide, TBL[v].lin, TBL[v].len, TBL[v].latw);
      do_strobe(TBL[v].addr, TBL[v].space);
      expect_burst(TBL[v].wide, TBL[v].lin, TBL[v].len, int'(TBL[v].late),
                   TBL[v].addr, TBL[v].space, $sformatf("R2-R10 table %0d", v));
    end

    // R4 R7 sweep: every offset, every wrapping length, both widths, min and max delay
    for (int w = 0; w < 2; w++)
      for (int ln = 0; ln < 3; ln++) begin
        if (w == 0 && ln == 2) continue;
        for (int lt = 0; lt < 2; lt++)
          for (int o = 0; o < ((4 << ln) >> w); o++) begin
            do_cfg(1'b1, w[0], 1'b0, ln[1:0], lt ? 5'd16 : 5'd2);
            do_strobe(AW'(32'h200 + o), 2'd0);
            expect_burst(w[0], 1'b0, ln[1:0], lt ? 16 : 2, AW'(32'h200 + o), 2'd0, "R4 sweep");
          end
      end

    // R8 restart mid-burst
    do_cfg(1'b1, 1'b0, 1'b0, 2'd1, 5'd4);
    do_strobe(20'h00010, 2'd0);
    repeat (6) @(negedge clk);
    chk("R8 running", 32'(beat_valid), 32'd1);
    do_strobe(20'h00023, 2'd0);
    expect_burst(1'b0, 1'b0, 2'd1, 4, 20'h00023, 2'd0, "R8");

    // R11 config write after strobe leaves the burst alone
    do_cfg(1'b1, 1'b1, 1'b0, 2'd2, 5'd3);
    do_strobe(20'h0001D, 2'd0);
    cfg_wr = 1'b1; cfg_len = 2'd0; cfg_linear = 1'b1; cfg_lat = 5'd16; cfg_wide = 1'b0;
    expect_burst(1'b1, 1'b0, 2'd2, 3, 20'h0001D, 2'd0, "R11");

    // R9 single reads: config space, protection space, bursting disabled
    do_cfg(1'b1, 1'b0, 1'b0, 2'd1, 5'd5);
    do_strobe(20'h00777, 2'd2);
    expect_single(5, 20'h00777, 6, "R9 config space");
    do_strobe(20'h00ABC, 2'd3);
    expect_single(5, 20'h00ABC, 2, "R9 protection space");
    do_cfg(1'b0, 1'b0, 1'b0, 2'd1, 5'd2);
    do_strobe(20'h00013, 2'd0);
    expect_single(2, 20'h00013, 4, "R9 disabled");

    // R1 reset during a burst
    do_cfg(1'b1, 1'b0, 1'b0, 2'd1, 5'd2);
    do_strobe(20'h00040, 2'd0);
    repeat (4) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1 reset mid-burst valid", 32'(beat_valid), 32'd0);
    chk("R1 reset mid-burst grp_end_n", 32'(grp_end_n), 32'd1);
    do_strobe(20'h00040, 2'd0);
    expect_single(2, 20'h00040, 1, "R1 burst disabled after reset");

    summary();
  end
endmodule